// File: doc/BRIEF.md
# Reorder Buffer Dispatch Selector

This block holds the scheduling state of a circular reorder buffer with 24 slots and chooses, in every cycle, which in-flight instructions go to the execution pipes. Each slot records an instruction class (ordinary, branch or memory), two source tags with their ready flags, a dispatched flag, an executed flag and a valid flag. Operand values, the ALUs and the data cache are outside the block. Only the slot indices that this block picks leave it.

Writeback tags are compared against every stored source tag, and a match marks that source ready. A writeback also marks its own slot as executed. Four searches run from the oldest slot toward the newest: one for a pending branch, one for a pending memory operation, and two in series for the two oldest data-ready ordinary operations. A small signed balance counter rises with branch issue and memory dispatch and falls with memory issue and branch dispatch. It decides which of two ordinary-operation stations gets the oldest ready ordinary operation, and whether the other station may take a second one. Executed slots retire from the oldest end, in program order.

Top module: `rob_dispatch_sel`

## Requirements
- R1: An accepted issue fills the slot shown on `iss_slot`, and that index then advances, wrapping from 23 to 0. `iss_kind` 0 means ordinary, 1 means branch and 2 means memory. When all 24 slots are valid, `iss_ready` is low and an issue request has no effect at all, including on the balance counter.
- R2: A writeback tag sets the ready flag of every stored source whose tag is equal to it, including a source of the instruction being issued in the same cycle. It also marks the slot with that index as executed.
- R3: When `brq_free` is high, `br_go` presents the oldest valid, not-yet-dispatched branch. That slot is never presented again. When `brq_free` is low, no branch is dispatched.
- R4: When `memq_free` is high, `mem_go` presents the oldest valid, not-yet-dispatched memory operation, under the same rules as branches.
- R5: An ordinary operation is a candidate when it is valid, not dispatched, and both of its sources are ready. When both stations are free, the oldest candidate goes to station 0 if the counter is negative and to station 1 otherwise. The second-oldest candidate goes to the other station, unless a memory operation is pending (negative counter) or a branch is pending (counter not negative).
- R6: When only station 0 is free, the oldest candidate goes to station 0 if the counter is negative, or if no branch is pending.
- R7: When only station 1 is free, the oldest candidate goes to station 1 if the counter is not negative, or if no memory operation is pending. When neither station is free, nothing goes to either of them.
- R8: The counter takes a net +1 for each branch issue and each memory dispatch, and a net -1 for each memory issue and each branch dispatch in a cycle. It saturates to the range -4 to +3 and is visible on `bal_level`.
- R9: The oldest slot retires, one per cycle and in order, once it is valid and executed. A later slot that has executed waits behind an older one that has not.
- R10: After reset the buffer is empty, the counter is 0, `iss_ready` is high, `iss_slot` is 0 and no dispatch or retire is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| iss_valid | input | 1 | Issue request |
| iss_kind | input | 2 | Class: 0 ordinary, 1 branch, 2 memory |
| iss_src1_tag | input | 5 | First source tag |
| iss_src1_rdy | input | 1 | First source already available |
| iss_src2_tag | input | 5 | Second source tag |
| iss_src2_rdy | input | 1 | Second source already available |
| iss_ready | output | 1 | Buffer can accept an issue |
| iss_slot | output | 5 | Slot that the next issue fills |
| wb0_valid | input | 1 | Writeback bus 0 active |
| wb0_tag | input | 5 | Writeback bus 0 slot tag |
| wb1_valid | input | 1 | Writeback bus 1 active |
| wb1_tag | input | 5 | Writeback bus 1 slot tag |
| st0_free | input | 1 | Station 0 can take an ordinary operation |
| st1_free | input | 1 | Station 1 can take an ordinary operation |
| brq_free | input | 1 | Branch slot can take a branch |
| memq_free | input | 1 | Memory slot can take a memory operation |
| br_go | output | 1 | Branch dispatched this cycle |
| br_slot | output | 5 | Slot of that branch |
| mem_go | output | 1 | Memory operation dispatched this cycle |
| mem_slot | output | 5 | Slot of that memory operation |
| alu0_go | output | 1 | Ordinary operation sent to station 0 |
| alu0_slot | output | 5 | Slot sent to station 0 |
| alu1_go | output | 1 | Ordinary operation sent to station 1 |
| alu1_slot | output | 5 | Slot sent to station 1 |
| ret_go | output | 1 | Oldest slot retires this cycle |
| ret_slot | output | 5 | Slot that retires |
| bal_level | output | 3 | Signed balance counter |

## Verification
Dispatch and retire outputs are combinational. They are due in the same cycle that the stored state and the free inputs allow them, and the matching slot is marked as taken at the next rising edge. An issue, a writeback or a counter change therefore shows on the outputs one edge after the cycle that carries it. The bench drives every input just after a falling edge and samples one nanosecond later. As a result, each table row's expected values describe the state left by the rows before it, combined with the current row's free flags.

// File: rtl/rob_pkg.sv
package rob_pkg;

    typedef enum logic [1:0] {
        KIND_ORD = 2'd0,
        KIND_BR  = 2'd1,
        KIND_MEM = 2'd2
    } op_kind_e;

endpackage

// File: rtl/rob_age_scan.sv
// Finds the first set bit of a mask, starting at a rotating origin (oldest slot).
module rob_age_scan #(
    parameter int DEPTH = 24,
    parameter int IW    = $clog2(DEPTH)
) (
    input  logic [IW-1:0]    origin,
    input  logic [DEPTH-1:0] mask,
    output logic             found,
    output logic [IW-1:0]    idx
);

    int pos;

    always_comb begin
        found = 1'b0;
        idx   = '0;
        pos   = 0;
        for (int k = 0; k < DEPTH; k++) begin
            pos = int'(origin) + k;
            if (pos >= DEPTH) pos = pos - DEPTH;
            if (!found && mask[pos]) begin
                found = 1'b1;
                idx   = pos[IW-1:0];
            end
        end
    end

endmodule

// File: rtl/rob_steer.sv
// Decides which station(s) receive the two oldest ready ordinary operations.
module rob_steer #(
    parameter int IW = 5
) (
    input  logic          st0_free,
    input  logic          st1_free,
    input  logic          neg,
    input  logic          br_pend,
    input  logic          mem_pend,
    input  logic          a_ok,
    input  logic [IW-1:0] a_idx,
    input  logic          b_ok,
    input  logic [IW-1:0] b_idx,
    output logic          go0,
    output logic [IW-1:0] slot0,
    output logic          go1,
    output logic [IW-1:0] slot1
);

    always_comb begin
        go0   = 1'b0;
        go1   = 1'b0;
        slot0 = a_idx;
        slot1 = a_idx;
        if (st0_free && st1_free) begin
            if (neg) begin
                go0   = a_ok;
                slot0 = a_idx;
                go1   = b_ok && !mem_pend;
                slot1 = b_idx;
            end else begin
                go1   = a_ok;
                slot1 = a_idx;
                go0   = b_ok && !br_pend;
                slot0 = b_idx;
            end
        end else if (st0_free) begin
            go0 = a_ok && (neg || !br_pend);
        end else if (st1_free) begin
            go1 = a_ok && (!neg || !mem_pend);
        end
    end

endmodule

// File: rtl/rob_balance.sv
// Net saturating update of the signed balance counter.
module rob_balance #(
    parameter int W = 3
) (
    input  logic signed [W-1:0] cur,
    input  logic                br_iss,
    input  logic                br_disp,
    input  logic                mem_iss,
    input  logic                mem_disp,
    output logic signed [W-1:0] nxt
);

    localparam int LO = -(2 ** (W - 1));
    localparam int HI = (2 ** (W - 1)) - 1;

    int sum;

    always_comb begin
        sum = int'(cur) + int'(br_iss) + int'(mem_disp) - int'(mem_iss) - int'(br_disp);
        if (sum > HI) sum = HI;
        if (sum < LO) sum = LO;
        nxt = sum[W-1:0];
    end

endmodule

// File: rtl/rob_dispatch_sel.sv
module rob_dispatch_sel #(
    parameter int DEPTH = 24,
    parameter int BAL_W = 3,
    parameter int IW    = $clog2(DEPTH)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    iss_valid,
    input  logic [1:0]              iss_kind,
    input  logic [IW-1:0]           iss_src1_tag,
    input  logic                    iss_src1_rdy,
    input  logic [IW-1:0]           iss_src2_tag,
    input  logic                    iss_src2_rdy,
    output logic                    iss_ready,
    output logic [IW-1:0]           iss_slot,
    input  logic                    wb0_valid,
    input  logic [IW-1:0]           wb0_tag,
    input  logic                    wb1_valid,
    input  logic [IW-1:0]           wb1_tag,
    input  logic                    st0_free,
    input  logic                    st1_free,
    input  logic                    brq_free,
    input  logic                    memq_free,
    output logic                    br_go,
    output logic [IW-1:0]           br_slot,
    output logic                    mem_go,
    output logic [IW-1:0]           mem_slot,
    output logic                    alu0_go,
    output logic [IW-1:0]           alu0_slot,
    output logic                    alu1_go,
    output logic [IW-1:0]           alu1_slot,
    output logic                    ret_go,
    output logic [IW-1:0]           ret_slot,
    output logic signed [BAL_W-1:0] bal_level
);
    import rob_pkg::*;

    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic          vld;
        op_kind_e      kind;
        logic [IW-1:0] t1;
        logic          r1;
        logic [IW-1:0] t2;
        logic          r2;
        logic          disp;
        logic          done;
    } slot_t;

    typedef struct packed {
        slot_t [DEPTH-1:0]       ent;
        logic [IW-1:0]           head;
        logic [IW-1:0]           tail;
        logic [CW-1:0]           cnt;
        logic signed [BAL_W-1:0] bal;
    } state_t;

    state_t st_q, st_d;

    function automatic logic [IW-1:0] step_idx(input logic [IW-1:0] x);
        return (x == IW'(DEPTH - 1)) ? '0 : x + 1'b1;
    endfunction

    // Candidate masks per class
    logic [DEPTH-1:0] br_mask, mem_mask, ord_mask, ord_mask_b;
    logic             br_found, mem_found, a_ok, b_ok;
    logic [IW-1:0]    br_idx, mem_idx, a_idx, b_idx;

    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            br_mask[i]  = st_q.ent[i].vld && !st_q.ent[i].disp && st_q.ent[i].kind == KIND_BR;
            mem_mask[i] = st_q.ent[i].vld && !st_q.ent[i].disp && st_q.ent[i].kind == KIND_MEM;
            ord_mask[i] = st_q.ent[i].vld && !st_q.ent[i].disp && st_q.ent[i].kind == KIND_ORD
                          && st_q.ent[i].r1 && st_q.ent[i].r2;
            ord_mask_b[i] = ord_mask[i] && !(a_ok && int'(a_idx) == i);
        end
    end

    rob_age_scan #(.DEPTH(DEPTH), .IW(IW)) i_scan_br (
        .origin(st_q.tail), .mask(br_mask), .found(br_found), .idx(br_idx)
    );
    rob_age_scan #(.DEPTH(DEPTH), .IW(IW)) i_scan_mem (
        .origin(st_q.tail), .mask(mem_mask), .found(mem_found), .idx(mem_idx)
    );
    rob_age_scan #(.DEPTH(DEPTH), .IW(IW)) i_scan_ord_a (
        .origin(st_q.tail), .mask(ord_mask), .found(a_ok), .idx(a_idx)
    );
    rob_age_scan #(.DEPTH(DEPTH), .IW(IW)) i_scan_ord_b (
        .origin(st_q.tail), .mask(ord_mask_b), .found(b_ok), .idx(b_idx)
    );

    logic go0, go1;
    logic [IW-1:0] slot0, slot1;

    rob_steer #(.IW(IW)) i_steer (
        .st0_free(st0_free),
        .st1_free(st1_free),
        .neg     (st_q.bal[BAL_W-1]),
        .br_pend (br_found),
        .mem_pend(mem_found),
        .a_ok    (a_ok),
        .a_idx   (a_idx),
        .b_ok    (b_ok),
        .b_idx   (b_idx),
        .go0     (go0),
        .slot0   (slot0),
        .go1     (go1),
        .slot1   (slot1)
    );

    logic full, do_iss, do_ret, do_br, do_mem;
    logic signed [BAL_W-1:0] bal_nxt;

    assign full   = (st_q.cnt == CW'(DEPTH));
    assign do_iss = iss_valid && !full;
    assign do_ret = st_q.ent[st_q.tail].vld && st_q.ent[st_q.tail].done;
    assign do_br  = br_found && brq_free;
    assign do_mem = mem_found && memq_free;

    rob_balance #(.W(BAL_W)) i_balance (
        .cur     (st_q.bal),
        .br_iss  (do_iss && iss_kind == 2'(KIND_BR)),
        .br_disp (do_br),
        .mem_iss (do_iss && iss_kind == 2'(KIND_MEM)),
        .mem_disp(do_mem),
        .nxt     (bal_nxt)
    );

    // Next-state computation
    always_comb begin
        st_d = st_q;
        for (int i = 0; i < DEPTH; i++) begin
            if (st_q.ent[i].vld) begin
                if ((wb0_valid && st_q.ent[i].t1 == wb0_tag) || (wb1_valid && st_q.ent[i].t1 == wb1_tag))
                    st_d.ent[i].r1 = 1'b1;
                if ((wb0_valid && st_q.ent[i].t2 == wb0_tag) || (wb1_valid && st_q.ent[i].t2 == wb1_tag))
                    st_d.ent[i].r2 = 1'b1;
                if ((wb0_valid && int'(wb0_tag) == i) || (wb1_valid && int'(wb1_tag) == i))
                    st_d.ent[i].done = 1'b1;
            end
        end
        if (do_br)  st_d.ent[br_idx].disp  = 1'b1;
        if (do_mem) st_d.ent[mem_idx].disp = 1'b1;
        if (go0)    st_d.ent[slot0].disp   = 1'b1;
        if (go1)    st_d.ent[slot1].disp   = 1'b1;
        if (do_ret) begin
            st_d.ent[st_q.tail].vld = 1'b0;
            st_d.tail = step_idx(st_q.tail);
        end
        if (do_iss) begin
            st_d.ent[st_q.head].vld  = 1'b1;
            st_d.ent[st_q.head].kind = op_kind_e'(iss_kind);
            st_d.ent[st_q.head].t1   = iss_src1_tag;
            st_d.ent[st_q.head].r1   = iss_src1_rdy
                                       || (wb0_valid && wb0_tag == iss_src1_tag)
                                       || (wb1_valid && wb1_tag == iss_src1_tag);
            st_d.ent[st_q.head].t2   = iss_src2_tag;
            st_d.ent[st_q.head].r2   = iss_src2_rdy
                                       || (wb0_valid && wb0_tag == iss_src2_tag)
                                       || (wb1_valid && wb1_tag == iss_src2_tag);
            st_d.ent[st_q.head].disp = 1'b0;
            st_d.ent[st_q.head].done = 1'b0;
            st_d.head = step_idx(st_q.head);
        end
        st_d.cnt = st_q.cnt + CW'(do_iss) - CW'(do_ret);
        st_d.bal = bal_nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign iss_ready = !full;
    assign iss_slot  = st_q.head;
    assign br_go     = do_br;
    assign br_slot   = br_idx;
    assign mem_go    = do_mem;
    assign mem_slot  = mem_idx;
    assign alu0_go   = go0;
    assign alu0_slot = slot0;
    assign alu1_go   = go1;
    assign alu1_slot = slot1;
    assign ret_go    = do_ret;
    assign ret_slot  = st_q.tail;
    assign bal_level = st_q.bal;

endmodule

// File: rtl/rob_dispatch_chk.sv
module rob_dispatch_chk #(
    parameter int DEPTH = 24,
    parameter int BAL_W = 3,
    parameter int IW    = $clog2(DEPTH)
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    iss_valid,
    input logic [1:0]              iss_kind,
    input logic                    iss_ready,
    input logic [IW-1:0]           iss_slot,
    input logic                    st0_free,
    input logic                    st1_free,
    input logic                    brq_free,
    input logic                    memq_free,
    input logic                    br_go,
    input logic [IW-1:0]           br_slot,
    input logic                    mem_go,
    input logic [IW-1:0]           mem_slot,
    input logic                    alu0_go,
    input logic [IW-1:0]           alu0_slot,
    input logic                    alu1_go,
    input logic [IW-1:0]           alu1_slot,
    input logic                    ret_go,
    input logic [IW-1:0]           ret_slot,
    input logic signed [BAL_W-1:0] bal_level
);

    localparam int HI = (2 ** (BAL_W - 1)) - 1;

    AST_FULL_HOLDS_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        !iss_ready |=> iss_slot == $past(iss_slot)); // R1
    AST_BR_SLOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        !brq_free |-> !br_go); // R3
    AST_BR_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
        br_go |=> !(br_go && br_slot == $past(br_slot))); // R3
    AST_MEM_SLOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        !memq_free |-> !mem_go); // R4
    AST_MEM_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_go |=> !(mem_go && mem_slot == $past(mem_slot))); // R4
    AST_STATIONS_DISTINCT: assert property (@(posedge clk) disable iff (!rst_n)
        (alu0_go && alu1_go) |-> alu0_slot != alu1_slot); // R5
    AST_ST0_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        !st0_free |-> !alu0_go); // R7
    AST_ST1_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        !st1_free |-> !alu1_go); // R7
    AST_BAL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(bal_level) - int'($past(bal_level)) <= 2) &&
        (int'(bal_level) - int'($past(bal_level)) >= -2)); // R8
    AST_BAL_BR_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_valid && iss_ready && iss_kind == 2'd1 && !br_go && !mem_go && int'(bal_level) != HI)
        |=> int'(bal_level) == int'($past(bal_level)) + 1); // R8
    AST_BAL_SAT_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_valid && iss_ready && iss_kind == 2'd1 && !br_go && !mem_go && int'(bal_level) == HI)
        |=> int'(bal_level) == HI); // R8
    AST_RETIRE_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        ret_go |=> (!ret_go || int'(ret_slot) ==
            ((int'($past(ret_slot)) == DEPTH - 1) ? 0 : int'($past(ret_slot)) + 1))); // R9

endmodule

bind rob_dispatch_sel rob_dispatch_chk #(.DEPTH(DEPTH), .BAL_W(BAL_W), .IW(IW)) i_rob_dispatch_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .iss_valid(iss_valid),
    .iss_kind (iss_kind),
    .iss_ready(iss_ready),
    .iss_slot (iss_slot),
    .st0_free (st0_free),
    .st1_free (st1_free),
    .brq_free (brq_free),
    .memq_free(memq_free),
    .br_go    (br_go),
    .br_slot  (br_slot),
    .mem_go   (mem_go),
    .mem_slot (mem_slot),
    .alu0_go  (alu0_go),
    .alu0_slot(alu0_slot),
    .alu1_go  (alu1_go),
    .alu1_slot(alu1_slot),
    .ret_go   (ret_go),
    .ret_slot (ret_slot),
    .bal_level(bal_level)
);

// File: tb/test_rob_dispatch_sel.sv
`timescale 1ns/1ps
module test_rob_dispatch_sel;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic rst_n;
    logic iss_valid, iss_src1_rdy, iss_src2_rdy, iss_ready;
    logic [1:0] iss_kind;
    logic [4:0] iss_src1_tag, iss_src2_tag, iss_slot;
    logic wb0_valid, wb1_valid;
    logic [4:0] wb0_tag, wb1_tag;
    logic st0_free, st1_free, brq_free, memq_free;
    logic br_go, mem_go, alu0_go, alu1_go, ret_go;
    logic [4:0] br_slot, mem_slot, alu0_slot, alu1_slot, ret_slot;
    logic signed [2:0] bal_level;

    rob_dispatch_sel i_rob_dispatch_sel (
        .clk(clk), .rst_n(rst_n),
        .iss_valid(iss_valid), .iss_kind(iss_kind),
        .iss_src1_tag(iss_src1_tag), .iss_src1_rdy(iss_src1_rdy),
        .iss_src2_tag(iss_src2_tag), .iss_src2_rdy(iss_src2_rdy),
        .iss_ready(iss_ready), .iss_slot(iss_slot),
        .wb0_valid(wb0_valid), .wb0_tag(wb0_tag),
        .wb1_valid(wb1_valid), .wb1_tag(wb1_tag),
        .st0_free(st0_free), .st1_free(st1_free),
        .brq_free(brq_free), .memq_free(memq_free),
        .br_go(br_go), .br_slot(br_slot),
        .mem_go(mem_go), .mem_slot(mem_slot),
        .alu0_go(alu0_go), .alu0_slot(alu0_slot),
        .alu1_go(alu1_go), .alu1_slot(alu1_slot),
        .ret_go(ret_go), .ret_slot(ret_slot),
        .bal_level(bal_level)
    );

    localparam logic [4:0] N  = 5'd31;  // "none" marker for tags and expected slots
    localparam logic [1:0] KO = 2'd0, KB = 2'd1, KM = 2'd2, KX = 2'd3;

    typedef struct packed {
        logic [1:0]        ik;
        logic [4:0]        t1;
        logic              r1;
        logic [4:0]        t2;
        logic              r2;
        logic [4:0]        w0;
        logic [4:0]        w1;
        logic              f0;
        logic              f1;
        logic [4:0]        ebr;
        logic [4:0]        emem;
        logic [4:0]        ea0;
        logic [4:0]        ea1;
        logic [4:0]        eret;
        logic signed [2:0] ebal;
    } row_t;

    // Expected values describe the outputs in the row's own cycle, before its issue/writeback commit.
    localparam row_t TBL [16] = '{
        '{KO, 5'd0, 1'b1, 5'd0, 1'b1, N,    N,    1'b0, 1'b0, N,    N,    N,    N,    N,    3'sd0},
        '{KB, 5'd0, 1'b0, 5'd0, 1'b0, N,    N,    1'b0, 1'b0, N,    N,    N,    N,    N,    3'sd0},
        '{KM, 5'd0, 1'b0, 5'd0, 1'b0, N,    N,    1'b1, 1'b0, 5'd1, N,    N,    N,    N,    3'sd1},
        '{KX, 5'd0, 1'b0, 5'd0, 1'b0, N,    N,    1'b1, 1'b0, N,    5'd2, 5'd0, N,    N,    -3'sd1},
        '{KO, 5'd0, 1'b0, 5'd0, 1'b1, 5'd0, 5'd2, 1'b1, 1'b1, N,    N,    N,    N,    N,    3'sd0},
        '{KO, 5'd1, 1'b0, 5'd0, 1'b1, N,    N,    1'b1, 1'b1, N,    N,    N,    5'd3, 5'd0, 3'sd0},
        '{KO, 5'd0, 1'b1, 5'd0, 1'b1, 5'd1, N,    1'b1, 1'b1, N,    N,    N,    N,    N,    3'sd0},
        '{KX, 5'd0, 1'b0, 5'd0, 1'b0, N,    N,    1'b1, 1'b1, N,    N,    5'd5, 5'd4, 5'd1, 3'sd0},
        '{KB, 5'd0, 1'b0, 5'd0, 1'b0, 5'd3, 5'd4, 1'b0, 1'b0, N,    N,    N,    N,    5'd2, 3'sd0},
        '{KO, 5'd0, 1'b1, 5'd0, 1'b1, N,    N,    1'b1, 1'b0, 5'd6, N,    N,    N,    5'd3, 3'sd1},
        '{KX, 5'd0, 1'b0, 5'd0, 1'b0, 5'd5, N,    1'b1, 1'b1, N,    N,    N,    5'd7, 5'd4, 3'sd0},
        '{KO, 5'd0, 1'b1, 5'd0, 1'b1, N,    N,    1'b0, 1'b0, N,    N,    N,    N,    5'd5, 3'sd0},
        '{KO, 5'd0, 1'b1, 5'd0, 1'b1, N,    N,    1'b0, 1'b0, N,    N,    N,    N,    N,    3'sd0},
        '{KM, 5'd0, 1'b0, 5'd0, 1'b0, N,    N,    1'b0, 1'b0, N,    N,    N,    N,    N,    3'sd0},
        '{KX, 5'd0, 1'b0, 5'd0, 1'b0, N,    N,    1'b1, 1'b1, N,    5'd10, 5'd8, N,   N,    -3'sd1},
        '{KX, 5'd0, 1'b0, 5'd0, 1'b0, N,    N,    1'b1, 1'b1, N,    N,    N,    5'd9, N,    3'sd0}
    };

    int errs = 0;
    int checks = 0;
    bit done_flag = 1'b0;

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errs++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int enc(input logic go, input logic [4:0] s);
        return go ? int'(s) : 31;
    endfunction

    task automatic set_in(input logic [1:0] ik, input logic [4:0] t1, input logic r1,
                          input logic [4:0] t2, input logic r2, input logic [4:0] w0,
                          input logic [4:0] w1, input logic f0, input logic f1);
        iss_valid    = (ik != KX);
        iss_kind     = (ik == KX) ? KO : ik;
        iss_src1_tag = t1;
        iss_src1_rdy = r1;
        iss_src2_tag = t2;
        iss_src2_rdy = r2;
        wb0_valid    = (w0 != N);
        wb0_tag      = (w0 != N) ? w0 : 5'd0;
        wb1_valid    = (w1 != N);
        wb1_tag      = (w1 != N) ? w1 : 5'd0;
        st0_free     = f0;
        st1_free     = f1;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        set_in(KX, 5'd0, 1'b0, 5'd0, 1'b0, N, N, 1'b0, 1'b0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        brq_free  = 1'b1;
        memq_free = 1'b1;
        do_reset();
        #1;
        // R10: empty state after reset
        chk("R10 iss_ready", int'(iss_ready), 1);
        chk("R10 iss_slot", int'(iss_slot), 0);
        chk("R10 bal_level", int'(bal_level), 0);
        chk("R10 no dispatch", enc(br_go, br_slot) + enc(mem_go, mem_slot)
                               + enc(alu0_go, alu0_slot) + enc(alu1_go, alu1_slot), 124);
        chk("R10 no retire", enc(ret_go, ret_slot), 31);

        // Table walk: rows 4-7 also cover writeback wake-up and issue bypass (R2)
        for (int i = 0; i < 16; i++) begin
            @(negedge clk);
            set_in(TBL[i].ik, TBL[i].t1, TBL[i].r1, TBL[i].t2, TBL[i].r2,
                   TBL[i].w0, TBL[i].w1, TBL[i].f0, TBL[i].f1);
            #1;
            chk($sformatf("R3 branch row %0d", i), enc(br_go, br_slot), int'(TBL[i].ebr));
            chk($sformatf("R4 memory row %0d", i), enc(mem_go, mem_slot), int'(TBL[i].emem));
            chk($sformatf("R5 station0 row %0d", i), enc(alu0_go, alu0_slot), int'(TBL[i].ea0));
            chk($sformatf("R5 station1 row %0d", i), enc(alu1_go, alu1_slot), int'(TBL[i].ea1));
            chk($sformatf("R9 retire row %0d", i), enc(ret_go, ret_slot), int'(TBL[i].eret));
            chk($sformatf("R8 balance row %0d", i), int'(bal_level), int'(TBL[i].ebal));
        end

        // Upper saturation and single-station rules with a branch held pending
        brq_free = 1'b0;
        do_reset();
        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            set_in(KB, 5'd0, 1'b0, 5'd0, 1'b0, N, N, 1'b0, 1'b0);
        end
        @(negedge clk);
        set_in(KO, 5'd0, 1'b1, 5'd0, 1'b1, N, N, 1'b0, 1'b0);
        #1;
        chk("R8 saturate at +3", int'(bal_level), 3);
        chk("R3 branch slot busy", enc(br_go, br_slot), 31);
        @(negedge clk);
        set_in(KX, 5'd0, 1'b0, 5'd0, 1'b0, N, N, 1'b1, 1'b0);
        #1;
        chk("R6 station0 held by pending branch", enc(alu0_go, alu0_slot), 31);
        chk("R6 station1 untouched", enc(alu1_go, alu1_slot), 31);
        @(negedge clk);
        set_in(KX, 5'd0, 1'b0, 5'd0, 1'b0, N, N, 1'b0, 1'b1);
        #1;
        chk("R7 station1 non-negative", enc(alu1_go, alu1_slot), 5);

        // Lower saturation, full buffer, ignored issue, wrap
        brq_free  = 1'b1;
        memq_free = 1'b0;
        do_reset();
        for (int k = 0; k < 24; k++) begin
            @(negedge clk);
            set_in(KM, 5'd0, 1'b0, 5'd0, 1'b0, N, N, 1'b0, 1'b0);
        end
        @(negedge clk);
        set_in(KB, 5'd0, 1'b0, 5'd0, 1'b0, N, N, 1'b0, 1'b0);
        #1;
        chk("R1 full stalls issue", int'(iss_ready), 0);
        chk("R8 saturate at -4", int'(bal_level), -4);
        @(negedge clk);
        set_in(KX, 5'd0, 1'b0, 5'd0, 1'b0, 5'd0, N, 1'b0, 1'b0);
        #1;
        chk("R1 issue while full ignored (balance)", int'(bal_level), -4);
        chk("R1 issue while full ignored (slot)", int'(iss_slot), 0);
        chk("R3 no branch from ignored issue", enc(br_go, br_slot), 31);
        @(negedge clk);
        set_in(KX, 5'd0, 1'b0, 5'd0, 1'b0, N, N, 1'b0, 1'b0);
        #1;
        chk("R9 oldest retires", enc(ret_go, ret_slot), 0);
        @(negedge clk);
        memq_free = 1'b1;
        set_in(KX, 5'd0, 1'b0, 5'd0, 1'b0, N, N, 1'b0, 1'b0);
        #1;
        chk("R1 ready after retire", int'(iss_ready), 1);
        chk("R1 slot index wrapped", int'(iss_slot), 0);
        chk("R4 oldest memory after wrap", enc(mem_go, mem_slot), 1);

        done_flag = 1'b1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done_flag) begin
            errs++;
            checks++;
            $display("FAIL R10 watchdog actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

endmodule